// File: doc/BRIEF.md
# Audio Event Status and Interrupt Controller

This block gathers event indications from an audio subsystem into one 8-bit status register whose flags stay set until software reads the register. The sources are converter clipping, completion of gain/volume slews, loss of lock on either of two serial audio interfaces, and a debounced change of a jack-status vector. A second register holds one interrupt-enable bit per flag, and the active-low, open-drain style `irq_n` output is pulled low while any enabled flag is set.

Software reaches the block through a simple register port: a 2-bit address, a write strobe with write data, and a read strobe. Read data is combinational from the addressed register. A read strobe at the status address clears the register at the next clock edge, except for flags whose event arrives in the same cycle. A control register holds a run bit, a jack-detect enable bit and a 2-bit debounce-period selector.

Three state machines sit inside. The slew tracker has states `SLW_IDLE` and `SLW_ACTIVE`. It moves from idle to active when any controller becomes busy. It moves from active back to idle, and emits a one-cycle finish pulse, when the last busy controller completes. The jack debouncer has states `DEB_STABLE` and `DEB_SETTLE`. It moves from stable to settle when the input differs from the accepted value. In settle it restarts its count when the input moves to yet another value. It falls back to stable without an event when the input returns to the accepted value or detection is disabled. It goes to stable with a change event when the count expires. The power-up arm has states `ARM_WAIT` and `ARM_SPENT`. It leaves wait, forcing the jack-change flag once, the first time the run or jack-enable bit is 1 after reset.

Top module: `audio_evt_irq`

## Requirements
- R1: The status register keeps clip at bit 7, slew-complete at bit 6, unlock at bit 5 and jack-change at bit 1. All other bits of the status and enable registers read 0, even after writing 0xFF.
- R2: A flag stays set once set. A read strobe at address 0 returns the current value and clears the register at that clock edge.
- R3: An event that arrives in the same cycle as a clearing read is kept and is visible to the next read.
- R4: `irq_n` is 0 while (status AND enable) is non-zero and 1 otherwise. After reset, enable is 0 and `irq_n` is 1.
- R5: A high on `clip_dac` or `clip_adc` sets bit 7.
- R6: `slew_start[i]` marks controller i busy and `slew_done[i]` marks it idle. Bit 6 is set only when the last busy controller goes idle, not when an earlier one finishes.
- R7: A pulse on `iface_soft_done` sets bit 6.
- R8: A rising edge on `unlock_a` or `unlock_b` sets bit 5. A level held high does not set it again after it has been cleared.
- R9: With jack detection enabled (control bit 1), a change of `jack_state` that stays unchanged for P = 4 << (2*sel) cycles sets bit 1, where sel is control bits 5:4 (4, 16, 64 or 256 cycles). The flag is not set before P cycles and is set within P+4 cycles.
- R10: A further change of `jack_state` before the period expires restarts the count. A return to the previously accepted value before expiry produces no flag.
- R11: The first time after reset that control bit 0 (run) or bit 1 (jack enable) reads 1, bit 1 is set once. Later enables do not set it.
- R12: Address 0 is status, 1 is enable and 2 is control, and all three reset to 0. Writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 control) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears status when addressed |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| clip_dac | input | 1 | Playback path at or above full scale |
| clip_adc | input | 1 | Record path at or above full scale |
| slew_start | input | NS | Per-controller slew start pulses |
| slew_done | input | NS | Per-controller slew completion pulses |
| iface_soft_done | input | 1 | Interface soft-start/stop completion pulse |
| unlock_a | input | 1 | First audio interface unlocked |
| unlock_b | input | 1 | Second audio interface unlocked |
| jack_state | input | JW | Raw jack-status vector |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A slew tracker with a stale busy bit would either never report completion or report it after the first of several slews. Either fault shows at the next status read, one cycle after the last `slew_done`. A debouncer whose counter fails to restart, or that accepts a glitch, raises bit 1 at the wrong time. Reads placed just before and just after the expected window reveal this within P+4 cycles. Lost events in the clearing cycle, a wrong arm state and leaking mask bits all appear on the very next read or `irq_n` sample.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
    localparam int FS_BIT  = 7;
    localparam int SLD_BIT = 6;
    localparam int ULK_BIT = 5;
    localparam int JCH_BIT = 1;
    localparam logic [7:0] FLAG_MASK = 8'hE2;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_ENABLE = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_JEN    = 1;
    localparam int CTRL_SEL_LO = 4;
    localparam logic [7:0] CTRL_MASK = 8'h33;

    typedef enum logic { SLW_IDLE, SLW_ACTIVE } slew_state_t;
    typedef enum logic { DEB_STABLE, DEB_SETTLE } deb_state_t;
    typedef enum logic { ARM_WAIT, ARM_SPENT } arm_state_t;
endpackage

// File: rtl/slew_tracker.sv
module slew_tracker
    import evt_status_pkg::*;
#(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] start,
    input  logic [NS-1:0] done,
    output logic          finish
);
    logic [NS-1:0] busy_q, busy_d;
    slew_state_t   st_q, st_d;

    // a start in the same cycle as a done keeps the controller busy
    always_comb busy_d = (busy_q & ~done) | start;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLW_IDLE:   if (|busy_d)  st_d = SLW_ACTIVE;
            SLW_ACTIVE: if (!(|busy_d)) st_d = SLW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SLW_IDLE;
            busy_q <= '0;
        end else begin
            st_q   <= st_d;
            busy_q <= busy_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) finish <= 1'b0;
        else        finish <= (st_q == SLW_ACTIVE) && !(|busy_d);
    end
endmodule

// File: rtl/jack_debounce.sv
module jack_debounce
    import evt_status_pkg::*;
#(
    parameter int JW   = 4,
    parameter int BASE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    sel,
    input  logic [JW-1:0] jack,
    output logic          changed
);
    localparam int MAXP = BASE << 6;
    localparam int CW   = $clog2(MAXP) + 1;

    deb_state_t    st_q, st_d;
    logic [JW-1:0] acc_q, acc_d, cand_q, cand_d;
    logic [CW-1:0] cnt_q, cnt_d, limit;
    logic          hit;

    always_comb limit = CW'(BASE) << {sel, 1'b0};

    always_comb begin
        st_d   = st_q;
        acc_d  = acc_q;
        cand_d = cand_q;
        cnt_d  = cnt_q;
        hit    = 1'b0;
        unique case (st_q)
            DEB_STABLE: begin
                if (!en) begin
                    acc_d = jack;
                end else if (jack != acc_q) begin
                    st_d   = DEB_SETTLE;
                    cand_d = jack;
                    cnt_d  = '0;
                end
            end
            DEB_SETTLE: begin
                if (!en) begin
                    st_d  = DEB_STABLE;
                    acc_d = jack;
                end else if (jack == acc_q) begin
                    st_d = DEB_STABLE;
                end else if (jack != cand_q) begin
                    cand_d = jack;
                    cnt_d  = '0;
                end else if (cnt_q == limit - CW'(1)) begin
                    st_d  = DEB_STABLE;
                    acc_d = cand_q;
                    hit   = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DEB_STABLE;
            acc_q  <= '0;
            cand_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            acc_q  <= acc_d;
            cand_q <= cand_d;
            cnt_q  <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) changed <= 1'b0;
        else        changed <= hit;
    end
endmodule

// File: rtl/audio_evt_irq.sv
module audio_evt_irq
    import evt_status_pkg::*;
#(
    parameter int NS       = 4,
    parameter int JW       = 4,
    parameter int DEB_BASE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          clip_dac,
    input  logic          clip_adc,
    input  logic [NS-1:0] slew_start,
    input  logic [NS-1:0] slew_done,
    input  logic          iface_soft_done,
    input  logic          unlock_a,
    input  logic          unlock_b,
    input  logic [JW-1:0] jack_state,
    output logic          irq_n
);
    logic [7:0] status_q, status_d, enable_q, ctrl_q, set_vec;
    logic [1:0] unl_prev;
    logic       slew_fin, jack_chg, first_fire, rd_clr;
    arm_state_t arm_q, arm_d;

    slew_tracker #(.NS(NS)) u_slew (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (slew_start),
        .done   (slew_done),
        .finish (slew_fin)
    );

    jack_debounce #(.JW(JW), .BASE(DEB_BASE)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q[CTRL_JEN]),
        .sel     (ctrl_q[CTRL_SEL_LO +: 2]),
        .jack    (jack_state),
        .changed (jack_chg)
    );

    // power-up arm: the jack flag is forced once on the first enable
    always_comb begin
        arm_d      = arm_q;
        first_fire = 1'b0;
        unique case (arm_q)
            ARM_WAIT: if (ctrl_q[CTRL_RUN] || ctrl_q[CTRL_JEN]) begin
                arm_d      = ARM_SPENT;
                first_fire = 1'b1;
            end
            ARM_SPENT: arm_d = ARM_SPENT;
        endcase
    end

    always_comb begin
        set_vec          = '0;
        set_vec[FS_BIT]  = clip_dac | clip_adc;
        set_vec[SLD_BIT] = slew_fin | iface_soft_done;
        set_vec[ULK_BIT] = |({unlock_b, unlock_a} & ~unl_prev);
        set_vec[JCH_BIT] = jack_chg | first_fire;
    end

    always_comb rd_clr   = reg_rd && (reg_addr == ADDR_STATUS);
    always_comb status_d = (rd_clr ? 8'h00 : status_q) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            ctrl_q   <= '0;
            unl_prev <= '0;
            arm_q    <= ARM_WAIT;
        end else begin
            status_q <= status_d;
            unl_prev <= {unlock_b, unlock_a};
            arm_q    <= arm_d;
            if (reg_wr && reg_addr == ADDR_ENABLE) enable_q <= reg_wdata & FLAG_MASK;
            if (reg_wr && reg_addr == ADDR_CTRL)   ctrl_q   <= reg_wdata & CTRL_MASK;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_STATUS: reg_rdata = status_q;
            ADDR_ENABLE: reg_rdata = enable_q;
            ADDR_CTRL:   reg_rdata = ctrl_q;
            default:     reg_rdata = 8'h00;
        endcase
    end

    always_comb irq_n = ~|(status_q & enable_q);
endmodule

// File: rtl/audio_evt_irq_chk.sv
module audio_evt_irq_chk
    import evt_status_pkg::*;
#(
    parameter int NS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    reg_addr,
    input logic          reg_rd,
    input logic [7:0]    reg_rdata,
    input logic          clip_dac,
    input logic          clip_adc,
    input logic          unlock_a,
    input logic          irq_n,
    input logic [NS-1:0] slew_done,
    input logic [7:0]    status_q,
    input logic [7:0]    enable_q,
    input logic [7:0]    set_vec,
    input logic          slew_fin
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STATUS) |-> ((reg_rdata & ~FLAG_MASK) == 8'h00));

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == ADDR_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_STATUS) |=> (status_q == $past(set_vec)));

    a_r3_clip_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_dac || clip_adc) |=> status_q[FS_BIT]);

    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == 8'h00) |-> irq_n);

    a_r6_finish_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        slew_fin |-> ($past(slew_done) != '0));

    a_r8_unlock_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_a) |=> status_q[ULK_BIT]);
endmodule

bind audio_evt_irq audio_evt_irq_chk #(.NS(NS)) u_chk (.*);

// File: tb/audio_evt_irq_test.sv
module audio_evt_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int JW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          clip_dac = 1'b0, clip_adc = 1'b0;
    logic [NS-1:0] slew_start = '0, slew_done = '0;
    logic          iface_soft_done = 1'b0;
    logic          unlock_a = 1'b0, unlock_b = 1'b0;
    logic [JW-1:0] jack_state = '0;
    logic          irq_n;
    logic          irq_probe = 1'b0;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic [7:0] exp;
        bit         is_irq;
        string      tag;
    } item_t;
    item_t sb[$];

    audio_evt_irq #(.NS(NS), .JW(JW), .DEB_BASE(4)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pop expected items and compare away from the active edge
    always @(negedge clk) begin
        item_t it;
        if (reg_rd || irq_probe) begin
            if (sb.size() == 0) begin
                total++; fails++;
                $display("FAIL scoreboard empty actual=none expected=item");
            end else begin
                it = sb.pop_front();
                total++;
                if (it.is_irq) begin
                    if (irq_n !== it.exp[0]) begin
                        fails++;
                        $display("FAIL %s irq_n actual=%b expected=%b", it.tag, irq_n, it.exp[0]);
                    end
                end else if (reg_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.exp = e; it.is_irq = 1'b0; it.tag = tag;
        sb.push_back(it);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.exp = {7'd0, e}; it.is_irq = 1'b1; it.tag = tag;
        sb.push_back(it);
        irq_probe = 1'b1;
        @(posedge clk); #1;
        irq_probe = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R12 / R4: reset state
        rd(2'd0, 8'h00, "R12 status reset");
        rd(2'd1, 8'h00, "R12 enable reset");
        rd(2'd2, 8'h00, "R12 control reset");
        chk_irq(1'b1, "R4 irq released after reset");

        wr(2'd1, 8'hE2);
        rd(2'd1, 8'hE2, "R12 enable readback");

        // R5 / R2 / R4: clip from playback path
        @(posedge clk); #1; clip_dac = 1'b1;
        @(posedge clk); #1; clip_dac = 1'b0;
        chk_irq(1'b0, "R4 irq asserted by enabled flag");
        rd(2'd0, 8'h80, "R5 clip_dac sets bit7");
        rd(2'd0, 8'h00, "R2 read cleared status");
        chk_irq(1'b1, "R4 irq released after read");

        @(posedge clk); #1; clip_adc = 1'b1;
        @(posedge clk); #1; clip_adc = 1'b0;
        idle(3);
        rd(2'd0, 8'h80, "R2 R5 clip_adc sticky bit7");

        // R4: masked flag leaves irq released
        wr(2'd1, 8'h00);
        @(posedge clk); #1; clip_dac = 1'b1;
        @(posedge clk); #1; clip_dac = 1'b0;
        chk_irq(1'b1, "R4 masked flag keeps irq high");
        rd(2'd0, 8'h80, "R4 masked flag still in status");

        // R12: status writes ignored
        wr(2'd0, 8'hFF);
        rd(2'd0, 8'h00, "R12 status write ignored");

        // R6: several concurrent slews
        @(posedge clk); #1; slew_start = 4'b0011;
        @(posedge clk); #1; slew_start = '0;
        idle(2);
        @(posedge clk); #1; slew_done = 4'b0001;
        @(posedge clk); #1; slew_done = '0;
        idle(2);
        rd(2'd0, 8'h00, "R6 no flag after first of two slews");
        @(posedge clk); #1; slew_done = 4'b0010;
        @(posedge clk); #1; slew_done = '0;
        rd(2'd0, 8'h40, "R6 flag after last slew");

        // R7: interface soft completion
        @(posedge clk); #1; iface_soft_done = 1'b1;
        @(posedge clk); #1; iface_soft_done = 1'b0;
        rd(2'd0, 8'h40, "R7 soft completion sets bit6");

        // R8: unlock edges
        @(posedge clk); #1; unlock_a = 1'b1;
        idle(2);
        rd(2'd0, 8'h20, "R8 unlock_a rise sets bit5");
        rd(2'd0, 8'h00, "R8 held unlock does not re-set");
        @(posedge clk); #1; unlock_b = 1'b1;
        idle(1);
        rd(2'd0, 8'h20, "R8 unlock_b rise sets bit5");
        @(posedge clk); #1; unlock_a = 1'b0; unlock_b = 1'b0;
        idle(2);

        // R3: event in the clearing cycle survives
        @(posedge clk); #1; iface_soft_done = 1'b1;
        @(posedge clk); #1; iface_soft_done = 1'b0;
        idle(1);
        begin
            item_t it;
            @(posedge clk); #1;
            it.exp = 8'h40; it.is_irq = 1'b0; it.tag = "R3 read before same-cycle event";
            sb.push_back(it);
            reg_addr = 2'd0; reg_rd = 1'b1; clip_dac = 1'b1;
            @(posedge clk); #1;
            reg_rd = 1'b0; clip_dac = 1'b0;
        end
        rd(2'd0, 8'h80, "R3 same-cycle event kept");

        // R11: forced jack flag on first enable only
        wr(2'd2, 8'h02);
        rd(2'd0, 8'h02, "R11 first enable sets bit1");
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h03);
        idle(2);
        rd(2'd0, 8'h00, "R11 later enable no flag");

        // R9: debounce with sel=1 (16 cycles)
        wr(2'd2, 8'h12);
        idle(2);
        @(posedge clk); #1; jack_state = 4'h5;
        idle(8);
        rd(2'd0, 8'h00, "R9 flag not set before period");
        idle(20);
        rd(2'd0, 8'h02, "R9 flag set after period");

        // R10: restart on further change
        @(posedge clk); #1; jack_state = 4'h6;
        idle(10);
        @(posedge clk); #1; jack_state = 4'h7;
        idle(8);
        rd(2'd0, 8'h00, "R10 count restarted by new change");
        idle(20);
        rd(2'd0, 8'h02, "R10 flag after restarted period");

        // R10: glitch back to accepted value
        @(posedge clk); #1; jack_state = 4'h0;
        idle(3);
        @(posedge clk); #1; jack_state = 4'h7;
        idle(30);
        rd(2'd0, 8'h00, "R10 glitch gives no flag");

        // R9: sel=0 (4 cycles)
        wr(2'd2, 8'h02);
        idle(2);
        @(posedge clk); #1; jack_state = 4'h9;
        idle(8);
        rd(2'd0, 8'h02, "R9 short period flag");

        // R1: all flags together, mask bits only
        wr(2'd1, 8'hFF);
        rd(2'd1, 8'hE2, "R1 enable keeps flag bits only");
        @(posedge clk); #1;
        jack_state = 4'hA; clip_adc = 1'b1; iface_soft_done = 1'b1; unlock_b = 1'b1;
        @(posedge clk); #1;
        clip_adc = 1'b0; iface_soft_done = 1'b0;
        idle(10);
        chk_irq(1'b0, "R4 irq with all flags");
        rd(2'd0, 8'hE2, "R1 all flags layout");
        chk_irq(1'b1, "R4 irq after clearing read");

        idle(3);
        if (sb.size() != 0) begin
            total++; fails++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        summary();
        $finish;
    end
endmodule